// File: doc/BRIEF.md
# GPIO Pad Bank with Interrupt Status

This block is a bank of general-purpose I/O pads placed behind a small register bus. Each pad owns a 16-byte window with two words in use. The trigger word selects how the pad raises an interrupt and also carries a 3-bit function select that leaves the block for the pad multiplexer. The value word holds active-low input-enable and output-enable flags and the pad level.

Pad pins pass through a two-flop synchroniser before any detection. Each pad can raise its status bit on a rising edge, a falling edge, either edge, a high level or a low level. Status bits are packed 32 pads per word in a separate region from 0x800 upward, and software clears them by writing ones. A single registered interrupt line stays high while any status bit is set. Software reads the status words, clears the bits it will handle, and then services those pads.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero. All pads therefore have input and output enabled, drive level 0 and have no trigger, and `irq` is low.
- R2: Pad n's trigger word sits at byte address n*16. A read returns bit 26 (falling/low), bit 25 (rising/high), bit 24 (level select) and bits 2:0 (function select), with every other bit zero. Bits 2:0 drive `pad_func[3n+2:3n]`.
- R3: Pad n's value word sits at n*16+8. Bit 2 is input-enable_n and drives `pad_ie[n]` inverted. Bit 1 is output-enable_n and drives `pad_oe[n]` inverted. Bit 0 drives `pad_out[n]`. A read returns bits 2:1 as stored. Bit 0 reads back the synchronised pin when input is enabled, and the stored level otherwise.
- R4: With bit 24 clear, bit 25 sets status on a rising pin edge and bit 26 on a falling one, or on both edges when both bits are set. Status and `irq` appear on the second clock edge after the edge at which the pin change is first sampled.
- R5: With bit 24 set, bit 25 sets status on every cycle the synchronised pin is high, and bit 26 on every cycle it is low.
- R6: A pad whose trigger bits 26:24 are all clear never sets its status bit.
- R7: Pad n's status is bit n mod 32 of the word at 0x800 + (n/32)*4. Bits for pads at or beyond the pad count read zero.
- R8: A write of 1 to a status bit clears it. A write of 0 leaves the bit unchanged.
- R9: When a clear and a new trigger event reach the same status bit in the same cycle, the bit stays set. A still-true level condition therefore sets the bit again immediately.
- R10: `irq` is a register that is high exactly when at least one status bit is set.
- R11: Read data appears on the clock after `bus_rd`, with `rd_valid` high, and is zero otherwise. Offsets +4 and +0xC, pad windows beyond the pad count, and status words beyond the last bank read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Read data |
| pad_in | input | NPADS | Raw pin inputs |
| pad_out | output | NPADS | Drive levels |
| pad_oe | output | NPADS | Output enable, active high |
| pad_ie | output | NPADS | Input enable, active high |
| pad_func | output | 3*NPADS | Function select, 3 bits per pad |
| irq | output | 1 | Combined interrupt |

## Verification
A pin change that the bench applies is sampled at the next edge. It must show up as status and on `irq` two edges after that, so the bench checks `irq` low after the first and second edges and high after the third. Register writes take effect on the edge that samples the write, and pad outputs are checked at the following falling clock edge. Read data is checked at the falling edge that follows the sampling edge, together with `rd_valid`. To test clear-versus-set priority, the bench places a status clear on exactly the edge at which a delayed rising edge reaches detection. A reference model advances on each rising edge and is compared with every output at each falling edge.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPADS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic [NPADS-1:0]     pad_in,
  output logic [NPADS-1:0]     pad_out,
  output logic [NPADS-1:0]     pad_oe,
  output logic [NPADS-1:0]     pad_ie,
  output logic [3*NPADS-1:0]   pad_func,
  output logic                 irq
);
  localparam int NWORDS = (NPADS + 31) / 32;
  localparam int SW     = NWORDS * 32;

  // trig word per pad: [5]=neg/low [4]=pos/high [3]=level [2:0]=function
  logic [NPADS-1:0][5:0] cfg_q;
  // value word per pad: [2]=ie_n [1]=oe_n [0]=level
  logic [NPADS-1:0][2:0] val_q;
  logic [NPADS-1:0]      s1, s2, s3, ev;
  logic [SW-1:0]         sts_q, sts_d, clr;
  logic [31:0]           rd_mux;
  logic                  unused_addr;

  wire pad_wr = bus_wr && !bus_addr[11];
  wire sts_wr = bus_wr &&  bus_addr[11];
  assign unused_addr = ^bus_addr[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= pad_in; s2 <= s1; s3 <= s2;
    end

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    wire hit = pad_wr && (bus_addr[10:4] == 7'(i));
    wire lvl = cfg_q[i][3];
    wire pos = cfg_q[i][4];
    wire neg = cfg_q[i][5];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cfg_q[i] <= '0;
        val_q[i] <= '0;
      end else if (hit) begin
        if (bus_addr[3:2] == 2'd0) cfg_q[i] <= {bus_wdata[26:24], bus_wdata[2:0]};
        if (bus_addr[3:2] == 2'd2) val_q[i] <= bus_wdata[2:0];
      end

    assign ev[i] = lvl ? ((pos & s2[i]) | (neg & ~s2[i]))
                       : ((pos & s2[i] & ~s3[i]) | (neg & ~s2[i] & s3[i]));

    assign pad_out[i]          = val_q[i][0];
    assign pad_oe[i]           = ~val_q[i][1];
    assign pad_ie[i]           = ~val_q[i][2];
    assign pad_func[3*i +: 3]  = cfg_q[i][2:0];
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign clr[w*32 +: 32] = (sts_wr && bus_addr[10:2] == 9'(w)) ? bus_wdata : 32'd0;
  end

  assign sts_d = (sts_q & ~clr) | SW'(ev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sts_q <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq   <= |sts_d;
    end

  always_comb begin
    rd_mux = '0;
    if (!bus_addr[11]) begin
      for (int i = 0; i < NPADS; i++)
        if (bus_addr[10:4] == 7'(i)) begin
          if (bus_addr[3:2] == 2'd0)
            rd_mux = {5'd0, cfg_q[i][5:3], 21'd0, cfg_q[i][2:0]};
          else if (bus_addr[3:2] == 2'd2)
            rd_mux = {29'd0, val_q[i][2:1], val_q[i][2] ? val_q[i][0] : s2[i]};
        end
    end else begin
      for (int w = 0; w < NWORDS; w++)
        if (bus_addr[10:2] == 9'(w)) rd_mux = sts_q[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      rd_data  <= bus_rd ? rd_mux : 32'd0;
    end
endmodule

module gpio_bank_chk #(
  parameter int NPADS = 40
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic                      bus_rd,
  input logic [11:0]               bus_addr,
  input logic                      rd_valid,
  input logic [31:0]               rd_data,
  input logic                      irq,
  input logic [((NPADS+31)/32)*32-1:0] sts,
  input logic [NPADS*6-1:0]        cfg
);
  localparam int SW = ((NPADS + 31) / 32) * 32;
  logic [SW-1:0] trig_x;

  always_comb begin
    trig_x = '0;
    for (int i = 0; i < NPADS; i++) trig_x[i] = |cfg[6*i+3 +: 3];
  end

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|sts));  // R10
  AST_NO_TRIG_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & ~$past(sts)) & ~$past(trig_x)) == '0);  // R6
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts) & ~sts)) |-> $past(bus_wr && bus_addr[11]));  // R8
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(bus_rd));  // R11
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 32'd0);  // R11
endmodule

bind gpio_bank gpio_bank_chk #(.NPADS(NPADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq),
  .sts(sts_q), .cfg(cfg_q)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NPADS  = 40;
  localparam int NWORDS = (NPADS + 31) / 32;
  localparam int SW     = NWORDS * 32;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NPADS-1:0] pad_in = '0;
  logic rd_valid, irq;
  logic [31:0] rd_data;
  logic [NPADS-1:0] pad_out, pad_oe, pad_ie;
  logic [3*NPADS-1:0] pad_func;

  gpio_bank #(.NPADS(NPADS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_func(pad_func), .irq(irq));

  always #2 clk = ~clk;

  int vecs = 0, fails = 0;
  bit checking = 0, done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [5:0] m_cfg [NPADS];
  logic [2:0] m_val [NPADS];
  logic [SW-1:0] m_sts, m_ev, m_clr;
  logic [NPADS-1:0] hist[$];
  logic [31:0] exp_rd;
  logic exp_rv, exp_irq;

  function automatic logic [31:0] mread(input logic [11:0] a);
    int p, w;
    mread = 0;
    if (!a[11]) begin
      p = int'(a[10:4]);
      if (p < NPADS) begin
        if (a[3:2] == 0) mread = {5'd0, m_cfg[p][5:3], 21'd0, m_cfg[p][2:0]};
        if (a[3:2] == 2) mread = {29'd0, m_val[p][2:1], m_val[p][2] ? m_val[p][0] : hist[1][p]};
      end
    end else begin
      w = int'(a[10:2]);
      if (w < NWORDS) mread = m_sts[w*32 +: 32];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPADS; i++) begin m_cfg[i] = 0; m_val[i] = 0; end
      m_sts = 0; exp_rd = 0; exp_rv = 0; exp_irq = 0;
      hist.delete();
      for (int k = 0; k < 3; k++) hist.push_back('0);
    end else begin
      m_ev = 0; m_clr = 0;
      for (int i = 0; i < NPADS; i++) begin
        bit c, pv;
        c = hist[1][i]; pv = hist[2][i];
        if (m_cfg[i][3]) m_ev[i] = (m_cfg[i][4] && c) || (m_cfg[i][5] && !c);
        else m_ev[i] = (m_cfg[i][4] && c && !pv) || (m_cfg[i][5] && !c && pv);
      end
      exp_rv = bus_rd;
      exp_rd = bus_rd ? mread(bus_addr) : 32'd0;
      if (bus_wr && bus_addr[11] && int'(bus_addr[10:2]) < NWORDS)
        m_clr[int'(bus_addr[10:2])*32 +: 32] = bus_wdata;
      m_sts = (m_sts & ~m_clr) | m_ev;
      exp_irq = |m_sts;
      if (bus_wr && !bus_addr[11] && int'(bus_addr[10:4]) < NPADS) begin
        if (bus_addr[3:2] == 0) m_cfg[int'(bus_addr[10:4])] = {bus_wdata[26:24], bus_wdata[2:0]};
        if (bus_addr[3:2] == 2) m_val[int'(bus_addr[10:4])] = bus_wdata[2:0];
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      logic [NPADS-1:0] eo, eoe, eie;
      logic [3*NPADS-1:0] ef;
      for (int i = 0; i < NPADS; i++) begin
        eo[i] = m_val[i][0]; eoe[i] = !m_val[i][1]; eie[i] = !m_val[i][2];
        ef[3*i +: 3] = m_cfg[i][2:0];
      end
      chk("R10 model irq", 64'(irq), 64'(exp_irq));
      chk("R11 model rd_valid", 64'(rd_valid), 64'(exp_rv));
      chk("R11 model rd_data", 64'(rd_data), 64'(exp_rd));
      chk("R3 model pad_out", 64'(pad_out), 64'(eo));
      chk("R3 model pad_oe", 64'(pad_oe), 64'(eoe));
      chk("R3 model pad_ie", 64'(pad_ie), 64'(eie));
      chk("R2 model pad_func", 64'(pad_func[63:0]), 64'(ef[63:0]));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = rd_data;
    chk("R11 rd_valid one cycle after read", 64'(rd_valid), 64'd1);
  endtask

  task automatic setpin(input int i, input logic v);
    @(negedge clk); pad_in[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    checking = 1;
    chk("R1 irq after reset", 64'(irq), 64'd0);
    chk("R1 pad_oe after reset", 64'(pad_oe), 64'({NPADS{1'b1}}));
    chk("R1 pad_ie after reset", 64'(pad_ie), 64'({NPADS{1'b1}}));
    chk("R1 pad_out after reset", 64'(pad_out), 64'd0);
    rd(12'h038, d); chk("R1 value word reset", 64'(d), 64'd0);

    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, d); chk("R2 trigger word readback", 64'(d), 64'h0700_0007);
    chk("R2 pad_func pad5", 64'(pad_func[17:15]), 64'd7);
    wr(12'h050, 32'h0000_0006);
    rd(12'h050, d); chk("R2 function only", 64'(d), 64'h6);
    wr(12'h800, 32'hFFFF_FFFF);
    idle(1); chk("R8 all-ones clear drops irq", 64'(irq), 64'd0);
    rd(12'h800, d); chk("R8 word cleared", 64'(d), 64'd0);

    wr(12'h028, 32'h5);
    chk("R3 pad_out pad2", 64'(pad_out[2]), 64'd1);
    chk("R3 pad_oe pad2", 64'(pad_oe[2]), 64'd1);
    chk("R3 pad_ie pad2", 64'(pad_ie[2]), 64'd0);
    rd(12'h028, d); chk("R3 stored level when input off", 64'(d), 64'h5);
    wr(12'h078, 32'h2);
    setpin(7, 1); idle(3);
    rd(12'h078, d); chk("R3 pin level when input on", 64'(d), 64'h3);
    chk("R3 pad_oe pad7 off", 64'(pad_oe[7]), 64'd0);

    setpin(9, 1); idle(4); setpin(9, 0); idle(4);
    rd(12'h800, d); chk("R6 untriggered pad no status", 64'(d), 64'd0);
    chk("R6 irq quiet", 64'(irq), 64'd0);

    wr(12'h0A0, 32'h0200_0000);
    @(negedge clk); pad_in[10] = 1;
    @(negedge clk); chk("R4 not yet after edge 1", 64'(irq), 64'd0);
    @(negedge clk); chk("R4 not yet after edge 2", 64'(irq), 64'd0);
    @(negedge clk); chk("R4 irq after edge 3", 64'(irq), 64'd1);
    rd(12'h800, d); chk("R4 rising status", 64'(d), 64'h400);
    wr(12'h800, 32'h400);
    idle(1); chk("R8 clear drops irq", 64'(irq), 64'd0);
    setpin(10, 0); idle(4);
    rd(12'h800, d); chk("R4 falling ignored on rising pad", 64'(d), 64'd0);

    wr(12'h0B0, 32'h0400_0000);
    setpin(11, 1); idle(4);
    rd(12'h800, d); chk("R4 rising ignored on falling pad", 64'(d), 64'd0);
    setpin(11, 0); idle(4);
    rd(12'h800, d); chk("R4 falling status", 64'(d), 64'h800);
    wr(12'h800, 32'h800);

    wr(12'h0C0, 32'h0600_0000);
    setpin(12, 1); idle(4);
    rd(12'h800, d); chk("R4 both edges rise", 64'(d), 64'h1000);
    wr(12'h800, 32'h1000);
    setpin(12, 0); idle(4);
    rd(12'h800, d); chk("R4 both edges fall", 64'(d), 64'h1000);
    wr(12'h800, 32'h1000);

    wr(12'h230, 32'h0200_0000);
    setpin(35, 1); idle(4);
    rd(12'h804, d); chk("R7 pad35 in word1 bit3", 64'(d), 64'h8);
    rd(12'h800, d); chk("R7 word0 unaffected", 64'(d), 64'd0);
    wr(12'h804, 32'h0);
    rd(12'h804, d); chk("R8 zero write keeps bit", 64'(d), 64'h8);
    chk("R10 irq with pending bit", 64'(irq), 64'd1);
    wr(12'h804, 32'h8);
    rd(12'h804, d); chk("R8 one write clears", 64'(d), 64'd0);
    chk("R10 irq idle", 64'(irq), 64'd0);

    setpin(20, 1); idle(3);
    wr(12'h140, 32'h0300_0000); idle(2);
    rd(12'h800, d); chk("R5 level high status", 64'(d), 64'h10_0000);
    wr(12'h800, 32'h10_0000);
    rd(12'h800, d); chk("R9 level reasserts after clear", 64'(d), 64'h10_0000);
    setpin(20, 0); idle(3);
    wr(12'h800, 32'h10_0000);
    rd(12'h800, d); chk("R5 level high gone when low", 64'(d), 64'd0);
    wr(12'h140, 32'h0);

    wr(12'h150, 32'h0500_0000); idle(2);
    rd(12'h800, d); chk("R5 level low status", 64'(d), 64'h20_0000);
    setpin(21, 1); idle(3);
    wr(12'h800, 32'h20_0000);
    rd(12'h800, d); chk("R5 level low gone when high", 64'(d), 64'd0);

    wr(12'h0D0, 32'h0200_0000); idle(2);
    @(negedge clk); pad_in[13] = 1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1; bus_addr = 12'h800; bus_wdata = 32'h2000;
    @(negedge clk); bus_wr = 0;
    rd(12'h800, d); chk("R9 event wins over same-cycle clear", 64'(d), 64'h2000);
    wr(12'h800, 32'h2000);
    rd(12'h800, d); chk("R8 clear after collision", 64'(d), 64'd0);

    rd(12'h054, d); chk("R11 offset +4 reads zero", 64'(d), 64'd0);
    rd(12'h05C, d); chk("R11 offset +C reads zero", 64'(d), 64'd0);
    wr(12'h054, 32'hFFFF_FFFF);
    rd(12'h054, d); chk("R11 offset +4 write ignored", 64'(d), 64'd0);
    rd(12'h2D0, d); chk("R11 pad beyond count reads zero", 64'(d), 64'd0);
    wr(12'h2D8, 32'h1);
    idle(1); chk("R11 write beyond pads ignored", 64'(pad_out), 64'h4);
    rd(12'h808, d); chk("R11 status word beyond banks zero", 64'(d), 64'd0);
    rd(12'h050, d); chk("R2 pad5 trigger word kept", 64'(d), 64'h6);

    idle(4);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule